// File: doc/BRIEF.md
# Multi-standard I2S transmit framer

This block is the transmit side of a master-mode audio serial port. It takes sample words through a valid/ready handshake and shifts them out on a serial data line. Each word fills one channel slot, left slot first and then right. The block also produces the word-select or frame-sync line and gates the bit clock out to the pins. A separate clock generator supplies a one-cycle strobe at the start of every bit period and the level of the bit clock. The framer counts bit positions inside a two-slot frame and places each word according to the chosen standard: Philips, MSB-justified, LSB-justified, or PCM with a short or long frame sync.

The framing standard, the PCM sync length, the data-in-slot format, the idle clock polarity and the operating mode are plain inputs. They are captured on every clock while the block is disabled and frozen while it is enabled. Only the master-transmit mode is implemented; any other mode raises a flag and keeps the lines quiet. If no word is waiting when a slot begins, the previous word is sent again and a sticky underrun flag is raised.

Top module: `i2s_tx_framer`

## Requirements
- R1: After reset, and on the clock after any cycle with `en` low, `sd` and `ws` are 0 and `s_ready` is 0. While disabled, `sck` rests at the captured polarity level.
- R2: Philips (`cfg_std`=0): `ws` is 0 during the left slot and 1 during the right slot, and it changes one bit period before the slot's first (MSB) data bit.
- R3: MSB-justified (`cfg_std`=1): `ws` is 0 for the left slot and 1 for the right, changing in the same bit period as the MSB. Data bits follow the MSB in order, and the rest of the slot is 0.
- R4: LSB-justified (`cfg_std`=2): the word's LSB falls on the last bit of the slot. Leading unused positions are 0, and `ws` is the same as in R3.
- R5: PCM short sync (`cfg_std`=3, `cfg_pcm_long`=0): `ws` is 1 only in the last bit period of each frame, one period before the left slot's MSB. Data is placed as in R3.
- R6: PCM long sync (`cfg_std`=3, `cfg_pcm_long`=1): `ws` is 1 for the first 13 bit periods of the frame, starting with the left slot's MSB. Data is placed as in R3.
- R7: `cfg_fmt` selects data/slot lengths: 0 = 16/16, 1 = 16/32, 2 = 24/32, 3 = 32/32. Only the low data-length bits of `s_data` are sent, MSB first. Slot positions not covered by data carry 0.
- R8: `s_ready` is high for exactly one cycle, together with `bit_stb`, at the start of each slot. A word accepted there is sent in that slot, left then right.
- R9: If `s_valid` is low when a slot starts, the previous word is sent again and `underrun` goes to 1. It stays 1 until a cycle with `underrun_clr` high and no new underrun.
- R10: Changes on the configuration inputs while `en` is high have no effect until `en` has been low for a clock.
- R11: A captured `cfg_mode` other than 0 (master transmit) makes `unsupported` follow `en`. In that case the block never asserts `s_ready` and keeps `sd` and `ws` at 0.
- R12: While running, `sck` equals `sck_phase` XOR the captured `cfg_cpol`.
- R13: The first bit period after enabling is a lead-in with `sd`=0 and `ws` at its last-bit-of-frame value. The left slot follows it.
- R14: `sd` and `ws` change only on clocks that carry `bit_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Block enable; configuration is captured while low |
| cfg_std | input | 2 | Framing standard: 0 Philips, 1 MSB-justified, 2 LSB-justified, 3 PCM |
| cfg_pcm_long | input | 1 | PCM frame sync length: 0 short, 1 long |
| cfg_fmt | input | 2 | Data/slot length pair (see R7) |
| cfg_cpol | input | 1 | Idle bit clock level |
| cfg_mode | input | 2 | 0 master transmit, 1 master receive, 2 slave transmit, 3 slave receive |
| bit_stb | input | 1 | One-cycle strobe at the start of each bit period |
| sck_phase | input | 1 | Bit clock level from the clock generator |
| s_data | input | WORD_W | Sample word, right-aligned |
| s_valid | input | 1 | Sample word available |
| s_ready | output | 1 | Sample word taken this cycle |
| underrun_clr | input | 1 | Clears the underrun flag |
| sck | output | 1 | Bit clock to the pins |
| ws | output | 1 | Word select / frame sync |
| sd | output | 1 | Serial data |
| underrun | output | 1 | Sticky underrun flag |
| unsupported | output | 1 | Enabled with a mode other than master transmit |

## Verification
The main function is run under each of the five standards, paired with different formats and both polarities. Random words with random upper bits separate correct data placement from a slip of one position and from leakage of unused input bits into padding. The 16-in-32 and 24-in-32 cases under MSB- and LSB-justified framing show which end of the slot the padding sits at. A starved run shows the difference between a repeated word and a zero word, and a mid-run configuration change tests that the captured setting is held. A run in an unsupported mode tests that the block stays quiet.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

   typedef enum logic [1:0] {
      STD_PHILIPS = 2'd0,
      STD_MSBJ    = 2'd1,
      STD_LSBJ    = 2'd2,
      STD_PCM     = 2'd3
   } std_e;

   typedef enum logic [1:0] {
      FMT_D16S16 = 2'd0,
      FMT_D16S32 = 2'd1,
      FMT_D24S32 = 2'd2,
      FMT_D32S32 = 2'd3
   } fmt_e;

   localparam logic [1:0] MODE_MASTER_TX = 2'd0;

   typedef struct packed {
      std_e       std;
      logic       pcm_long;
      fmt_e       fmt;
      logic       cpol;
      logic [1:0] mode;
   } cfg_t;

   function automatic int slot_bits(fmt_e f);
      return (f == FMT_D16S16) ? 16 : 32;
   endfunction

   function automatic int data_bits(fmt_e f);
      case (f)
         FMT_D24S32: return 24;
         FMT_D32S32: return 32;
         default:    return 16;
      endcase
   endfunction

endpackage

// File: rtl/i2s_tx_cfg_hold.sv
module i2s_tx_cfg_hold
   import i2s_tx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  cfg_t cfg_in,
   output cfg_t cfg_q,
   output logic running,
   output logic unsupported
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (!en) begin
         cfg_q <= cfg_in;
      end
   end

   always_comb begin
      running     = en && (cfg_q.mode == MODE_MASTER_TX);
      unsupported = en && (cfg_q.mode != MODE_MASTER_TX);
   end

endmodule

// File: rtl/i2s_tx_bitpos.sv
module i2s_tx_bitpos
   import i2s_tx_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             running,
   input  logic             bit_stb,
   input  fmt_e             fmt,
   output logic [CNT_W-1:0] pos,
   output logic             lead_in,
   output logic             slot_start
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] slen;
   logic [CNT_W-1:0] last;

   always_comb begin
      slen       = CNT_W'(slot_bits(fmt));
      last       = CNT_W'(2 * slot_bits(fmt) - 1);
      pos        = lead_in ? last : cnt_q;
      slot_start = !lead_in && ((cnt_q == '0) || (cnt_q == slen));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !running) begin
         cnt_q   <= '0;
         lead_in <= 1'b1;
      end else if (bit_stb) begin
         lead_in <= 1'b0;
         if (lead_in || (cnt_q == last)) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/i2s_tx_lane.sv
module i2s_tx_lane
   import i2s_tx_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int CNT_W     = 6,
   parameter int LONG_SYNC = 13
) (
   input  cfg_t              cfg,
   input  logic [CNT_W-1:0]  pos,
   input  logic [WORD_W-1:0] word,
   output logic              sd_bit,
   output logic              ws_bit
);

   localparam int IDX_W = $clog2(WORD_W);

   logic [CNT_W-1:0] slen;
   logic [CNT_W-1:0] dlen;
   logic [CNT_W-1:0] last;
   logic [CNT_W-1:0] p;
   logic [CNT_W-1:0] nxt;
   logic [CNT_W-1:0] idx;
   logic             in_data;

   always_comb begin
      slen = CNT_W'(slot_bits(cfg.fmt));
      dlen = CNT_W'(data_bits(cfg.fmt));
      last = CNT_W'(2 * slot_bits(cfg.fmt) - 1);
      p    = (pos >= slen) ? (pos - slen) : pos;
      nxt  = (pos == last) ? '0 : (pos + 1'b1);

      if (cfg.std == STD_LSBJ) begin
         in_data = (p >= (slen - dlen));
         idx     = slen - 1'b1 - p;
      end else begin
         in_data = (p < dlen);
         idx     = dlen - 1'b1 - p;
      end
      sd_bit = in_data ? word[IDX_W'(idx)] : 1'b0;

      case (cfg.std)
         STD_PHILIPS: ws_bit = (nxt >= slen);
         STD_PCM:     ws_bit = cfg.pcm_long ? (pos < CNT_W'(LONG_SYNC)) : (pos == last);
         default:     ws_bit = (pos >= slen);
      endcase
   end

endmodule

// File: rtl/i2s_tx_framer.sv
module i2s_tx_framer
   import i2s_tx_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int MAX_SLOT  = 32,
   parameter int LONG_SYNC = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [1:0]        cfg_std,
   input  logic              cfg_pcm_long,
   input  logic [1:0]        cfg_fmt,
   input  logic              cfg_cpol,
   input  logic [1:0]        cfg_mode,
   input  logic              bit_stb,
   input  logic              sck_phase,
   input  logic [WORD_W-1:0] s_data,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic              underrun_clr,
   output logic              sck,
   output logic              ws,
   output logic              sd,
   output logic              underrun,
   output logic              unsupported
);

   localparam int CNT_W = $clog2(2 * MAX_SLOT);

   generate
      if (WORD_W < 32 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
         $error("WORD_W must be a power of two of at least 32");
      end
      if (MAX_SLOT != 32) begin : g_bad_slot
         $error("MAX_SLOT must be 32, the widest slot format");
      end
      if (LONG_SYNC < 1 || LONG_SYNC > 16) begin : g_bad_sync
         $error("LONG_SYNC must fit inside the shortest slot");
      end
   endgenerate

   cfg_t             cfg_in;
   cfg_t             cfg_q;
   logic             running;
   logic [CNT_W-1:0] pos;
   logic             lead_in;
   logic             slot_start;
   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] word_now;
   logic             sd_bit;
   logic             ws_bit;
   logic             take;

   always_comb begin
      cfg_in.std      = std_e'(cfg_std);
      cfg_in.pcm_long = cfg_pcm_long;
      cfg_in.fmt      = fmt_e'(cfg_fmt);
      cfg_in.cpol     = cfg_cpol;
      cfg_in.mode     = cfg_mode;
   end

   i2s_tx_cfg_hold u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .cfg_in      (cfg_in),
      .cfg_q       (cfg_q),
      .running     (running),
      .unsupported (unsupported)
   );

   i2s_tx_bitpos #(.CNT_W(CNT_W)) u_pos (
      .clk        (clk),
      .rst_n      (rst_n),
      .running    (running),
      .bit_stb    (bit_stb),
      .fmt        (cfg_q.fmt),
      .pos        (pos),
      .lead_in    (lead_in),
      .slot_start (slot_start)
   );

   always_comb begin
      take     = running && bit_stb && slot_start;
      s_ready  = take;
      word_now = (take && s_valid) ? s_data : word_q;
      sck      = running ? (sck_phase ^ cfg_q.cpol) : cfg_q.cpol;
   end

   i2s_tx_lane #(
      .WORD_W    (WORD_W),
      .CNT_W     (CNT_W),
      .LONG_SYNC (LONG_SYNC)
   ) u_lane (
      .cfg    (cfg_q),
      .pos    (pos),
      .word   (word_now),
      .sd_bit (sd_bit),
      .ws_bit (ws_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q   <= '0;
         underrun <= 1'b0;
      end else begin
         if (take && s_valid) begin
            word_q <= s_data;
         end
         if (take && !s_valid) begin
            underrun <= 1'b1;
         end else if (underrun_clr) begin
            underrun <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !running) begin
         sd <= 1'b0;
         ws <= 1'b0;
      end else if (bit_stb) begin
         sd <= lead_in ? 1'b0 : sd_bit;
         ws <= ws_bit;
      end
   end

endmodule

// File: rtl/i2s_tx_framer_chk.sv
module i2s_tx_framer_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic bit_stb,
   input logic s_valid,
   input logic s_ready,
   input logic underrun_clr,
   input logic ws,
   input logic sd,
   input logic underrun,
   input logic unsupported
);

   p_ready_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> (bit_stb && en));

   p_underrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ready && !s_valid) |=> underrun);

   p_underrun_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !underrun_clr) |=> underrun);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!sd && !ws));

   p_unsup_no_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      unsupported |-> !s_ready);

   p_unsup_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      unsupported |=> (!sd && !ws));

   p_change_on_strobe_r14: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !bit_stb) |=> ($stable(sd) && $stable(ws)));

endmodule

bind i2s_tx_framer i2s_tx_framer_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .en           (en),
   .bit_stb      (bit_stb),
   .s_valid      (s_valid),
   .s_ready      (s_ready),
   .underrun_clr (underrun_clr),
   .ws           (ws),
   .sd           (sd),
   .underrun     (underrun),
   .unsupported  (unsupported)
);

// File: tb/i2s_tx_framer_bench.sv
module i2s_tx_framer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [1:0]  cfg_std = 2'd0;
   logic        cfg_pcm_long = 1'b0;
   logic [1:0]  cfg_fmt = 2'd0;
   logic        cfg_cpol = 1'b0;
   logic [1:0]  cfg_mode = 2'd0;
   logic        bit_stb = 1'b0;
   logic        sck_phase = 1'b0;
   logic [31:0] s_data = '0;
   logic        s_valid = 1'b0;
   logic        s_ready;
   logic        underrun_clr = 1'b0;
   logic        sck, ws, sd, underrun, unsupported;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   string tag = "";

   always #5 clk = ~clk;

   i2s_tx_framer u_i2s_tx_framer (
      .clk(clk), .rst_n(rst_n), .en(en),
      .cfg_std(cfg_std), .cfg_pcm_long(cfg_pcm_long), .cfg_fmt(cfg_fmt),
      .cfg_cpol(cfg_cpol), .cfg_mode(cfg_mode),
      .bit_stb(bit_stb), .sck_phase(sck_phase),
      .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
      .underrun_clr(underrun_clr),
      .sck(sck), .ws(ws), .sd(sd), .underrun(underrun), .unsupported(unsupported)
   );

   // ---------------- stimulus feeders ----------------
   logic [31:0] wq[$];
   logic        feed_on = 1'b1;
   logic        pop_req = 1'b0;
   logic        stb_on = 1'b0;
   int          ph = 0;

   always @(posedge clk) begin
      #2;
      if (pop_req && wq.size() > 0) void'(wq.pop_front());
      s_valid = feed_on && (wq.size() > 0);
      s_data  = (wq.size() > 0) ? wq[0] : 32'h0;
      ph      = (ph + 1) % 4;
      bit_stb = stb_on && (ph == 0);
      sck_phase = (ph >= 2);
   end

   // ---------------- reference model ----------------
   int m_std = 0, m_long = 0, m_fmt = 0, m_cpol = 0, m_mode = 0;
   int m_b = 0;
   bit m_lead = 1'b1;
   logic [31:0] m_word = '0;
   bit m_ur = 1'b0;
   bit e_sd = 1'b0, e_ws = 1'b0;
   bit prev_stb = 1'b0;

   function automatic int len_slot(int f);
      return (f == 0) ? 16 : 32;
   endfunction

   function automatic int len_data(int f);
      return (f <= 1) ? 16 : ((f == 2) ? 24 : 32);
   endfunction

   function automatic bit ref_sd(int st, int f, logic [31:0] w, int at);
      bit img[32];
      int sl = len_slot(f);
      int dl = len_data(f);
      for (int k = 0; k < 32; k++) img[k] = 1'b0;
      for (int k = 0; k < dl; k++) begin
         if (st == 2) img[sl - dl + k] = w[dl - 1 - k];
         else         img[k] = w[dl - 1 - k];
      end
      return img[at % sl];
   endfunction

   function automatic bit ref_ws(int st, int lg, int f, int at);
      int sl = len_slot(f);
      case (st)
         0: return (((at + 1) % (2 * sl)) / sl) == 1;
         3: return lg ? (at < 13) : (at == 2 * sl - 1);
         default: return (at / sl) == 1;
      endcase
   endfunction

   function automatic string std_tag(int st, int lg);
      case (st)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         default: return lg ? "R6" : "R5";
      endcase
   endfunction

   task automatic check_bit(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         m_std = 0; m_long = 0; m_fmt = 0; m_cpol = 0; m_mode = 0;
         m_b = 0; m_lead = 1'b1; m_word = '0; m_ur = 1'b0;
         e_sd = 1'b0; e_ws = 1'b0; pop_req = 1'b0; prev_stb = 1'b0;
      end else begin
         bit run, e_rdy, e_sck;
         int sl, at;
         string rq;
         run = en && (m_mode == 0);
         sl  = len_slot(m_fmt);
         at  = m_lead ? (2 * sl - 1) : m_b;
         e_rdy = run && bit_stb && !m_lead && ((m_b % sl) == 0);
         e_sck = run ? (sck_phase ^ m_cpol[0]) : m_cpol[0];

         rq = {std_tag(m_std, m_long), " R7 ", tag};
         if (!en) rq = {rq, " R1"};
         if (!prev_stb) rq = {rq, " R14"};
         check_bit(rq, "sd", sd, e_sd);
         check_bit(rq, "ws", ws, e_ws);
         check_bit({"R8 ", tag}, "s_ready", s_ready, e_rdy);
         check_bit({"R9 ", tag}, "underrun", underrun, m_ur);
         check_bit({"R11 ", tag}, "unsupported", unsupported, en && (m_mode != 0));
         check_bit({"R12 ", tag}, "sck", sck, e_sck);

         pop_req = e_rdy && s_valid;
         if (run && bit_stb) begin
            logic [31:0] w;
            w = (e_rdy && s_valid) ? s_data : m_word;
            e_sd = m_lead ? 1'b0 : ref_sd(m_std, m_fmt, w, at);
            e_ws = ref_ws(m_std, m_long, m_fmt, at);
            if (e_rdy && s_valid) m_word = s_data;
            if (m_lead) m_b = 0;
            else        m_b = (m_b + 1) % (2 * sl);
            m_lead = 1'b0;
         end else if (!run) begin
            e_sd = 1'b0; e_ws = 1'b0; m_b = 0; m_lead = 1'b1;
         end
         if (e_rdy && !s_valid) m_ur = 1'b1;
         else if (underrun_clr) m_ur = 1'b0;
         if (!en) begin
            m_std = cfg_std; m_long = cfg_pcm_long; m_fmt = cfg_fmt;
            m_cpol = cfg_cpol; m_mode = cfg_mode;
         end
         prev_stb = bit_stb;
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog expired at %0t", $time);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   // ---------------- test sequence ----------------
   task automatic wait_clk(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic run_seg(string t, int st, int lg, int f, int cp, int md,
                          int nwords, int nbits);
      wait_clk(1);
      en = 1'b0;
      wait_clk(6);
      tag = t;
      cfg_std = st[1:0]; cfg_pcm_long = lg[0]; cfg_fmt = f[1:0];
      cfg_cpol = cp[0]; cfg_mode = md[1:0];
      wq.delete();
      for (int k = 0; k < nwords; k++) wq.push_back($urandom());
      wait_clk(3);
      en = 1'b1;
      wait_clk(nbits * 4);
      en = 1'b0;
      wait_clk(8);
   endtask

   initial begin
      stb_on = 1'b1;
      tag = "R1 reset";
      wait_clk(6);
      rst_n = 1'b1;
      wait_clk(4);

      run_seg("R2 R13 philips 16/16",   0, 0, 0, 0, 0, 12, 150);
      run_seg("R3 msb 24/32 cpol1",      1, 0, 2, 1, 0, 12, 170);
      run_seg("R4 lsb 16/32",            2, 0, 1, 0, 0, 12, 170);
      run_seg("R4 lsb 24/32",            2, 0, 2, 1, 0, 12, 170);
      run_seg("R5 pcm short 16/16",      3, 0, 0, 0, 0, 12, 150);
      run_seg("R6 pcm long 32/32",       3, 1, 3, 1, 0, 12, 170);
      run_seg("R6 pcm long 16/16",       3, 1, 0, 0, 0, 12, 150);

      // R9: starve after one word, then clear the flag
      run_seg("R9 underrun philips 16/32", 0, 0, 1, 0, 0, 1, 140);
      tag = "R9 clear";
      underrun_clr = 1'b1;
      wait_clk(1);
      underrun_clr = 1'b0;
      wait_clk(4);

      // R10: configuration changes while enabled are ignored
      wait_clk(1);
      tag = "R10 held config";
      cfg_std = 2'd1; cfg_fmt = 2'd0; cfg_cpol = 1'b0; cfg_mode = 2'd0;
      wq.delete();
      for (int k = 0; k < 16; k++) wq.push_back($urandom());
      wait_clk(3);
      en = 1'b1;
      wait_clk(60);
      cfg_std = 2'd2; cfg_fmt = 2'd3; cfg_cpol = 1'b1; cfg_mode = 2'd2;
      wait_clk(300);
      en = 1'b0;
      wait_clk(8);

      // R11: unsupported modes
      run_seg("R11 master rx", 0, 0, 0, 0, 1, 4, 40);
      run_seg("R11 slave rx",  1, 0, 2, 1, 3, 4, 40);

      // back to a normal run after an unsupported setting
      run_seg("R2 R12 philips 32/32 cpol1", 0, 0, 3, 1, 0, 12, 170);

      stb_on = 1'b0;
      wait_clk(4);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule